// File: doc/BRIEF.md
# Receive Data Transfer Engine with Burst Option

This block hands the data words of a bus-controller-to-terminal (receive) command over to the local subsystem. Validated words arrive from the bus receiver one at a time and are placed in a 32-word internal FIFO. The engine then moves them to the subsystem with a request/grant handshake. Each granted handshake is followed by write cycles on a 16-bit local data bus.

A static mode input selects between two ways of moving the words. In word-by-word mode, each stored word gets its own handshake and a one-cycle write. In block mode, the engine waits until the message has ended and every word is buffered. It then makes a single request and writes the whole FIFO on consecutive cycles. A request that is not granted within a programmable number of clocks is abandoned: the affected words are discarded and the message is marked as not fully delivered. The words that follow are still attempted.

When a message is over and nothing is left to move, the engine judges the block. If the command was not a mode code, the received count matched the commanded count, and every word reached the subsystem, the engine drives an active-low good-block strobe for two clocks.

Top module: `rx_xfer_engine`

## Requirements
- R1: Directly after reset, `dma_req` and `wr_en` are low and `gbr_n` is high.
- R2: With `burst_mode` low, every word stored during a message raises `dma_req`. A grant seen with `dma_req` high produces exactly one `wr_en` cycle on the following clock, carrying that word on `wr_data`, and words are written in arrival order.
- R3: If `dma_req` stays high for `tmo_limit` clocks (`tmo_limit` ≥ 1) without a grant, it drops. The pending word (word-by-word mode) or the whole buffered block (block mode) is discarded, and later words are still handled.
- R4: With `burst_mode` high, `dma_req` is not raised while a message is open. After `msg_end`, a single grant produces one `wr_en` per buffered word on consecutive clocks.
- R5: A message opens on `cmd_start`, which latches `cmd_wc` and `cmd_mode`, and closes on `msg_end`. The expected word count is `cmd_wc`, with the value 0 meaning 32.
- R6: Once a closed message has no words left to move, `gbr_n` goes low for exactly two clocks. This happens only if `cmd_mode` was low, the number of words received equals the expected count, and no handshake timed out.
- R7: `gbr_n` stays high after a mode-code message, after a count mismatch, or after any timeout. In all of these cases the received words are still written out.
- R8: `word_valid` pulses outside an open message are ignored. Words arriving while the FIFO holds 32 words are dropped, and they still count as received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_mode | input | 1 | 1 = one handshake per block, 0 = one handshake per word |
| tmo_limit | input | 8 | Clocks a request may wait for its grant |
| cmd_start | input | 1 | Opens a receive message |
| cmd_wc | input | 5 | Commanded word count, 0 means 32 |
| cmd_mode | input | 1 | Command is a mode code |
| word_valid | input | 1 | A validated data word is on `word_data` |
| word_data | input | 16 | Received data word |
| msg_end | input | 1 | Closes the open message |
| dma_req | output | 1 | Transfer request to the subsystem |
| dma_gnt | input | 1 | Grant from the subsystem |
| wr_en | output | 1 | Local bus write strobe |
| wr_data | output | 16 | Local bus write data |
| gbr_n | output | 1 | Active-low good-block strobe |

## Verification
The bench sweeps both modes over word counts of 1, 2, 3, 7, 31 and 32, with grant delays from one to three clocks. This separates per-word handshakes from single-block bursts and checks ordering and the back-to-back timing. Short and long blocks and mode-code commands show that data still flows while the good-block strobe is withheld. Denial patterns on the first word, the last word, alternate words and the block handshake show the exact timeout length, selective discarding, and suppression of the strobe. A 33-word block and stray words outside a message exercise the FIFO limit and the gating of input words.

// File: rtl/rx_xfer_engine.sv
module rx_xfer_engine #(
  parameter int DW = 16,
  parameter int DEPTH = 32,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          burst_mode,
  input  logic [TW-1:0] tmo_limit,
  input  logic          cmd_start,
  input  logic [$clog2(DEPTH)-1:0] cmd_wc,
  input  logic          cmd_mode,
  input  logic          word_valid,
  input  logic [DW-1:0] word_data,
  input  logic          msg_end,
  output logic          dma_req,
  input  logic          dma_gnt,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          gbr_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 2;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_XFER} st_t;

  st_t           st_q;
  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wptr_q, rptr_q, level;
  logic [CW-1:0] rcvd_q, exp_q;
  logic [TW-1:0] tmo_q;
  logic [1:0]    gbr_q;
  logic          open_q, ended_q, fail_q, mode_q;
  logic          store, eval, good;

  assign level   = wptr_q - rptr_q;
  assign store   = word_valid && open_q && (level != (AW+1)'(DEPTH));
  assign eval    = ended_q && st_q == S_IDLE && level == '0;
  assign good    = !mode_q && !fail_q && rcvd_q == exp_q;
  assign dma_req = st_q == S_REQ;
  assign wr_en   = st_q == S_XFER;
  assign wr_data = mem[rptr_q[AW-1:0]];
  assign gbr_n   = gbr_q == 2'd0;

  always_ff @(posedge clk)
    if (store) mem[wptr_q[AW-1:0]] <= word_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE; wptr_q <= '0; rptr_q <= '0; rcvd_q <= '0; exp_q <= '0;
      tmo_q <= '0; gbr_q <= '0; open_q <= 1'b0; ended_q <= 1'b0;
      fail_q <= 1'b0; mode_q <= 1'b0;
    end else begin
      if (gbr_q != 2'd0) gbr_q <= gbr_q - 2'd1;
      if (cmd_start) begin
        open_q  <= 1'b1;
        ended_q <= 1'b0;
        fail_q  <= 1'b0;
        rcvd_q  <= '0;
        mode_q  <= cmd_mode;
        exp_q   <= (cmd_wc == '0) ? CW'(DEPTH) : CW'(cmd_wc);
      end else if (msg_end && open_q) begin
        open_q  <= 1'b0;
        ended_q <= 1'b1;
      end
      if (word_valid && open_q && !cmd_start && rcvd_q != CW'(DEPTH + 1))
        rcvd_q <= rcvd_q + 1'b1;
      if (store) wptr_q <= wptr_q + 1'b1;
      if (eval) begin
        ended_q <= 1'b0;
        if (good) gbr_q <= 2'd2;
      end
      unique case (st_q)
        S_IDLE: begin
          tmo_q <= '0;
          if (level != '0 && (!burst_mode || ended_q)) st_q <= S_REQ;
        end
        S_REQ: begin
          if (dma_gnt) st_q <= S_XFER;
          else if (tmo_q + 1'b1 >= tmo_limit) begin
            st_q   <= S_IDLE;
            fail_q <= 1'b1;
            rptr_q <= burst_mode ? wptr_q : rptr_q + 1'b1;
          end else tmo_q <= tmo_q + 1'b1;
        end
        S_XFER: begin
          rptr_q <= rptr_q + 1'b1;
          if (!burst_mode || level == (AW+1)'(1)) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  a_r2_write_follows_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> $past(dma_req && dma_gnt));
  a_r3_req_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> tmo_q < tmo_limit);
  a_r4_no_req_while_open: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_mode && $rose(dma_req)) |-> !open_q);
  a_r4_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_mode && wr_en && level > (AW+1)'(1)) |=> wr_en);
  a_r6_two_clock_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gbr_n) |=> !gbr_n ##1 gbr_n);
  a_r7_no_pulse_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gbr_n) |-> (!fail_q && !mode_q));
  a_r8_no_empty_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> level != '0);
endmodule

// File: tb/rx_xfer_engine_test.sv
module rx_xfer_engine_test;
  logic clk = 0, rst_n = 0;
  logic burst_mode = 0, cmd_start = 0, cmd_mode = 0, word_valid = 0, msg_end = 0, dma_gnt = 0;
  logic [7:0] tmo_limit = 8'd4;
  logic [4:0] cmd_wc = 0;
  logic [15:0] word_data = 0;
  logic dma_req, wr_en, gbr_n;
  logic [15:0] wr_data;

  always #5 clk = ~clk;

  rx_xfer_engine uut (.clk, .rst_n, .burst_mode, .tmo_limit, .cmd_start, .cmd_wc,
    .cmd_mode, .word_valid, .word_data, .msg_end, .dma_req, .dma_gnt, .wr_en,
    .wr_data, .gbr_n);

  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] cap [64];
  int ncap, first_wr, last_wr, pulses, lastw, lowrun, hs, wcnt, reqrun, maxrun, gdelay;
  bit open_b, req_open;
  logic [63:0] deny;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (wr_en) begin
      if (ncap < 64) cap[ncap] = wr_data;
      if (ncap == 0) first_wr = cyc;
      last_wr = cyc;
      ncap++;
    end
    if (!gbr_n) lowrun++;
    else if (lowrun > 0) begin pulses++; lastw = lowrun; lowrun = 0; end
    if (dma_req) begin
      if (open_b && burst_mode) req_open = 1;
      wcnt++; reqrun++;
      if (reqrun > maxrun) maxrun = reqrun;
      dma_gnt = (wcnt >= gdelay) && !deny[hs];
    end else begin
      if (wcnt > 0) hs++;
      wcnt = 0; reqrun = 0; dma_gnt = 0;
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  function automatic logic [15:0] dval(input int m, input int i);
    return 16'((m * 256 + i) ^ 16'hA5C3);
  endfunction

  task automatic run_msg(input int m, input bit b, input int wc, input bit md, input int n,
                         input logic [63:0] dmask, input string tag);
    int expw, nexp, fails;
    logic [15:0] ev [64];
    bit dok;
    ncap = 0; pulses = 0; lastw = 0; hs = 0; maxrun = 0; req_open = 0;
    deny = dmask; gdelay = 1 + (m % 3); burst_mode = b;
    word_valid = 1; word_data = 16'hDEAD; tick();
    word_valid = 0;
    cmd_start = 1; cmd_wc = 5'(wc); cmd_mode = md; open_b = 1; tick();
    cmd_start = 0;
    for (int i = 0; i < n; i++) begin
      word_valid = 1; word_data = dval(m, i); tick();
      word_valid = 0; tick(5);
    end
    msg_end = 1; open_b = 0; tick();
    msg_end = 0;
    word_valid = 1; word_data = 16'hBEEF; tick();
    word_valid = 0;
    tick(140);
    expw = (wc == 0) ? 32 : wc;
    nexp = 0; fails = 0;
    for (int i = 0; i < n; i++) begin
      if (b) begin
        if (i < 32 && !dmask[0]) begin ev[nexp] = dval(m, i); nexp++; end
      end else if (!dmask[i]) begin ev[nexp] = dval(m, i); nexp++; end
    end
    if (b && dmask[0] && n > 0) fails = 1;
    if (!b) for (int i = 0; i < n; i++) if (dmask[i]) fails = 1;
    check(ncap == nexp, {tag, " write count"}, ncap, nexp);
    dok = 1;
    for (int i = 0; i < nexp && i < ncap; i++) if (cap[i] !== ev[i]) dok = 0;
    check(dok, {tag, " write data/order"}, int'(dok), 1);
    if (b && nexp > 0) begin
      check(last_wr - first_wr == nexp - 1, "R4 consecutive burst writes", last_wr - first_wr, nexp - 1);
      check(!req_open, "R4 no request while message open", int'(req_open), 0);
    end
    if (fails) check(maxrun == 4, "R3 request held tmo_limit clocks", maxrun, 4);
    if (!md && n == expw && !fails) begin
      check(pulses == 1, "R6 good block strobe present", pulses, 1);
      check(lastw == 2, "R6 strobe width", lastw, 2);
    end else
      check(pulses == 0, "R7 strobe suppressed", pulses, 0);
  endtask

  initial begin
    int wcs [6] = '{1, 2, 3, 7, 31, 0};
    int m = 0;
    tick(3);
    check(dma_req == 0 && wr_en == 0 && gbr_n == 1, "R1 reset outputs",
          {dma_req, wr_en, gbr_n}, 3'b001);
    rst_n = 1; tick(2);
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 6; k++) begin
        run_msg(m, b[0], wcs[k], 0, (wcs[k] == 0) ? 32 : wcs[k], 64'd0,
                b ? "R4 burst sweep" : "R2 word sweep");
        m++;
      end
    for (int b = 0; b < 2; b++) begin
      run_msg(m, b[0], 5, 0, 4, 64'd0, "R5 short block"); m++;
      run_msg(m, b[0], 5, 0, 6, 64'd0, "R5 long block"); m++;
      run_msg(m, b[0], 1, 1, 1, 64'd0, "R7 mode code data"); m++;
    end
    run_msg(m, 0, 6, 0, 6, 64'h1, "R3 first word denied"); m++;
    run_msg(m, 0, 6, 0, 6, 64'h20, "R3 last word denied"); m++;
    run_msg(m, 0, 8, 0, 8, 64'hAA, "R3 alternate words denied"); m++;
    run_msg(m, 1, 4, 0, 4, 64'h1, "R3 burst denied"); m++;
    run_msg(m, 1, 0, 0, 33, 64'd0, "R8 FIFO limit"); m++;
    run_msg(m, 0, 2, 0, 2, 64'd0, "R8 stray words ignored"); m++;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule